// File: doc/BRIEF.md
# Local Orientation Code Encoder

This block turns a 3x3 neighbourhood of 8-bit gray values into a compact local-structure code. Each accepted beat carries the nine window taps (arranged by upstream line buffers), the smoothed local average at the centre position, and a marker that says whether the centre sits on the image border. The block derives a significance threshold for the centre pixel from how far the pixel lies from its local average. A neighbour is counted as significantly darker when its value lies at or below the centre minus that threshold. Every neighbour has its own power-of-two weight, so each bit of the code belongs to exactly one direction.

Two neighbourhood modes are available. One uses only the four edge neighbours, which gives codes 0 to 15. The other adds the four diagonals and gives a full 8-bit code. A separate contrast flag compares the residual, normalised by the local average, with a programmable limit. A histogram stage downstream can count this flag in two extra bins next to the structure codes. Results leave through a valid/ready output with a two-cycle latency when the consumer does not stall.

Top module: `loc_encoder`

## Requirements
- R1: A neighbour sets its code bit exactly when its gray value is less than or equal to `centre - thr`. A value one above that reference leaves the bit clear.
- R2: `thr = floor(scale * |centre - smooth| / 16)`, where `scale` is unsigned fixed point with 2 integer and 4 fraction bits (16 means 1.0). Results above 255 saturate to 255.
- R3: When `thr` exceeds `centre`, no neighbour bit is set, whatever the neighbour values are.
- R4: With `cfg_n8=0` the code uses four bits: up=bit0 (weight 1), left=bit1 (2), right=bit2 (4), down=bit3 (8), and bits 7:4 are zero. All four set (15) marks an isolated significant point. None set (0) marks a full intersection.
- R5: With `cfg_n8=1` the eight neighbours take weights in raster order from the top-left: up-left 1, up 2, up-right 4, left 8, right 16, down-left 32, down 64, down-right 128.
- R6: `out_contrast` is 1 exactly when `|centre - smooth| * 256 > cfg_contrast * smooth`. `cfg_contrast` is a fraction with 8 bits (256 would mean 1.0).
- R7: A beat marked as border still produces an output beat. On that beat `out_code` is 0, `out_interior` is 0 and `out_contrast` is 0. Interior beats have `out_interior` = 1.
- R8: With `out_ready` held high, a beat accepted in cycle t appears on the outputs in cycle t+2, and the block takes one beat per cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values. When both pipeline stages are full, `in_ready` is 0. No beat is lost, duplicated or reordered.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_win | input | 72 | Window taps, tap k at bits [8k+7:8k], k = row*3 + column, centre is tap 4 |
| in_smooth | input | 8 | Smoothed local average at the centre |
| in_border | input | 1 | Centre pixel lies on the image border |
| cfg_n8 | input | 1 | 0: four-neighbour code, 1: eight-neighbour code |
| cfg_scale | input | 6 | Threshold scale, 2.4 fixed point |
| cfg_contrast | input | 8 | Contrast limit, 0.8 fixed point |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_code | output | 8 | Local-structure code |
| out_interior | output | 1 | 1 for an interior pixel, 0 for a border pixel |
| out_contrast | output | 1 | High local contrast flag |

## Verification
The bench aims at the threshold edges. It puts neighbours exactly on the reference and one above it, which catches a strict compare in place of the inclusive one. It uses a scale and residual large enough that the threshold overflows 8 bits, where a design without saturation wraps or lets dark neighbours through. It also uses a threshold larger than the centre, where an unsigned subtraction would wrap and set every bit. The contrast limit is set one step on each side of the decision point, the modes are switched between beats to expose wrong weight positions, and a long random stream with random stalls catches outputs that change during a stall or beats that are lost or doubled.

// File: rtl/loc_pkg.sv
// Package: shared geometry of the 3x3 window and default widths.
// Assumes taps are numbered in raster order, row*3 + column, centre at 4.
package loc_pkg;
    localparam int WIN_SIDE  = 3;
    localparam int WIN_TAPS  = WIN_SIDE * WIN_SIDE;
    localparam int CENTRE    = WIN_TAPS / 2;
    localparam int NBR_COUNT = WIN_TAPS - 1;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_C_INT = 2;
    localparam int DEF_C_FRC = 4;
    localparam int DEF_T_W   = 8;

    // Window tap that holds neighbour k (neighbours skip the centre).
    function automatic int nbr_tap(input int k);
        return (k < CENTRE) ? k : k + 1;
    endfunction
endpackage

// File: rtl/loc_thresh.sv
// loc_thresh: combinational significance threshold for one centre pixel.
// Computes |centre - smooth|, scales it by a fixed-point factor, saturates
// to the pixel range and forms the comparison reference centre - thr.
// Assumes scale is unsigned with C_FRC fraction bits.
module loc_thresh #(
    parameter int PIX_W = loc_pkg::DEF_PIX_W,
    parameter int C_INT = loc_pkg::DEF_C_INT,
    parameter int C_FRC = loc_pkg::DEF_C_FRC
) (
    input  logic [PIX_W-1:0]       centre,
    input  logic [PIX_W-1:0]       smooth,
    input  logic [C_INT+C_FRC-1:0] scale,
    output logic [PIX_W-1:0]       absd,
    output logic [PIX_W-1:0]       ref_val,
    output logic                   ref_ok
);
    localparam int C_W    = C_INT + C_FRC;
    localparam int PROD_W = C_W + PIX_W;
    localparam logic [PROD_W-1:0] MAXV = PROD_W'({PIX_W{1'b1}});

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    logic [PIX_W-1:0]  thr;

    // Absolute residual, scaled threshold with saturation, and reference.
    always_comb begin
        absd    = (centre >= smooth) ? (centre - smooth) : (smooth - centre);
        prod    = PROD_W'(scale) * PROD_W'(absd);
        shifted = prod >> C_FRC;
        thr     = (shifted > MAXV) ? {PIX_W{1'b1}} : shifted[PIX_W-1:0];
        ref_ok  = (centre >= thr);
        ref_val = centre - thr;
    end
endmodule

// File: rtl/loc_contrast.sv
// loc_contrast: combinational local-contrast flag.
// Flags residual/smooth > limit without a divider by cross-multiplying:
// absd * 2^T_W > limit * smooth. Assumes limit is a pure T_W-bit fraction.
module loc_contrast #(
    parameter int PIX_W = loc_pkg::DEF_PIX_W,
    parameter int T_W   = loc_pkg::DEF_T_W
) (
    input  logic [PIX_W-1:0] absd,
    input  logic [PIX_W-1:0] smooth,
    input  logic [T_W-1:0]   limit,
    output logic             high
);
    localparam int CW = PIX_W + T_W;

    logic [CW-1:0] lhs;
    logic [CW-1:0] rhs;

    // Cross-multiplied comparison of the normalised residual.
    always_comb begin
        lhs  = {absd, {T_W{1'b0}}};
        rhs  = CW'(limit) * CW'(smooth);
        high = (lhs > rhs);
    end
endmodule

// File: rtl/loc_compare.sv
// loc_compare: combinational neighbour comparators and code packing.
// One comparator per neighbour (raster order, centre skipped); the code is
// either all eight hit bits or the four edge bits packed into bits 3:0.
module loc_compare #(
    parameter int PIX_W = loc_pkg::DEF_PIX_W,
    parameter int NBR_N = loc_pkg::NBR_COUNT
) (
    input  logic [NBR_N*PIX_W-1:0] nbrs,
    input  logic [PIX_W-1:0]       ref_val,
    input  logic                   ref_ok,
    input  logic                   n8,
    output logic [NBR_N-1:0]       code
);
    logic [NBR_N-1:0] hit;

    // One inclusive comparator per neighbour.
    for (genvar k = 0; k < NBR_N; k++) begin : g_cmp
        assign hit[k] = ref_ok && (nbrs[k*PIX_W +: PIX_W] <= ref_val);
    end

    // Select full raster code or edge-only code (up, left, right, down).
    always_comb begin
        if (n8) begin
            code = hit;
        end else begin
            code    = '0;
            code[0] = hit[1];
            code[1] = hit[3];
            code[2] = hit[4];
            code[3] = hit[6];
        end
    end
endmodule

// File: rtl/loc_encoder.sv
// loc_encoder: two-stage pipelined local-structure encoder.
// Stage 1 registers the reference, neighbours and contrast flag; stage 2
// registers the packed code. Each stage advances when the next is free.
// Assumes upstream supplies a complete window per beat.
module loc_encoder #(
    parameter int PIX_W = loc_pkg::DEF_PIX_W,
    parameter int C_INT = loc_pkg::DEF_C_INT,
    parameter int C_FRC = loc_pkg::DEF_C_FRC,
    parameter int T_W   = loc_pkg::DEF_T_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [loc_pkg::WIN_TAPS*PIX_W-1:0]  in_win,
    input  logic [PIX_W-1:0]                    in_smooth,
    input  logic                                in_border,
    input  logic                                cfg_n8,
    input  logic [C_INT+C_FRC-1:0]              cfg_scale,
    input  logic [T_W-1:0]                      cfg_contrast,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [loc_pkg::NBR_COUNT-1:0]       out_code,
    output logic                                out_interior,
    output logic                                out_contrast
);
    localparam int NBR_N = loc_pkg::NBR_COUNT;
    localparam int NB_W  = NBR_N * PIX_W;

    logic [PIX_W-1:0] centre;
    logic [NB_W-1:0]  nbrs_in;
    logic [PIX_W-1:0] absd, ref_val;
    logic             ref_ok, contrast_hi;

    logic             s1_valid, s1_ref_ok, s1_n8, s1_border, s1_contrast;
    logic [NB_W-1:0]  s1_nbrs;
    logic [PIX_W-1:0] s1_ref;
    logic [NBR_N-1:0] code_c;
    logic             out_n8;
    logic             adv_out, adv_s1;

    assign centre = in_win[loc_pkg::CENTRE*PIX_W +: PIX_W];

    // Gather the eight neighbour taps in raster order.
    for (genvar k = 0; k < NBR_N; k++) begin : g_nbr
        assign nbrs_in[k*PIX_W +: PIX_W] = in_win[loc_pkg::nbr_tap(k)*PIX_W +: PIX_W];
    end

    loc_thresh #(.PIX_W(PIX_W), .C_INT(C_INT), .C_FRC(C_FRC)) u_thresh (
        .centre (centre),
        .smooth (in_smooth),
        .scale  (cfg_scale),
        .absd   (absd),
        .ref_val(ref_val),
        .ref_ok (ref_ok)
    );

    loc_contrast #(.PIX_W(PIX_W), .T_W(T_W)) u_contrast (
        .absd  (absd),
        .smooth(in_smooth),
        .limit (cfg_contrast),
        .high  (contrast_hi)
    );

    loc_compare #(.PIX_W(PIX_W), .NBR_N(NBR_N)) u_compare (
        .nbrs   (s1_nbrs),
        .ref_val(s1_ref),
        .ref_ok (s1_ref_ok),
        .n8     (s1_n8),
        .code   (code_c)
    );

    // Stage advance conditions (back-pressure chain).
    assign adv_out  = !out_valid || out_ready;
    assign adv_s1   = !s1_valid || adv_out;
    assign in_ready = adv_s1;

    // Stage 1: capture reference, neighbours, mode and contrast per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_nbrs     <= '0;
            s1_ref      <= '0;
            s1_ref_ok   <= 1'b0;
            s1_n8       <= 1'b0;
            s1_border   <= 1'b0;
            s1_contrast <= 1'b0;
        end else if (adv_s1) begin
            s1_valid    <= in_valid;
            s1_nbrs     <= nbrs_in;
            s1_ref      <= ref_val;
            s1_ref_ok   <= ref_ok;
            s1_n8       <= cfg_n8;
            s1_border   <= in_border;
            s1_contrast <= contrast_hi;
        end
    end

    // Stage 2: register the packed code, forcing border beats to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_code     <= '0;
            out_interior <= 1'b0;
            out_contrast <= 1'b0;
            out_n8       <= 1'b0;
        end else if (adv_out) begin
            out_valid    <= s1_valid;
            out_code     <= s1_border ? '0 : code_c;
            out_interior <= !s1_border;
            out_contrast <= s1_border ? 1'b0 : s1_contrast;
            out_n8       <= s1_n8;
        end
    end

    // Output holds while stalled.
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) &&
                                       $stable(out_interior) && $stable(out_contrast)));

    // Full pipeline under stall refuses input.
    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && out_valid && !out_ready) |-> !in_ready);

    // Accepted beat reaches stage 1 on the next cycle.
    assert_accept_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_valid);

    // Border beats leave with zero code and flags.
    assert_border_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_interior) |-> (out_code == '0 && !out_contrast));

    // Four-neighbour mode never sets diagonal-range bits.
    assert_n4_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_n8) |-> (out_code[NBR_N-1:4] == '0));
endmodule

// File: tb/loc_encoder_tb.sv
// loc_encoder_tb: behavioural reference model with expected-value queues,
// directed corner cases and a random stream with random back-pressure.
module loc_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [71:0] in_win = '0;
    logic [7:0]  in_smooth = '0;
    logic        in_border = 1'b0;
    logic        cfg_n8 = 1'b0;
    logic [5:0]  cfg_scale = 6'd16;
    logic [7:0]  cfg_contrast = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_code;
    logic        out_interior;
    logic        out_contrast;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit rand_ready = 0;
    bit monitor_on = 0;

    int exp_code[$];
    int exp_int[$];
    int exp_con[$];
    int exp_mode[$];

    bit         prev_stall = 0;
    logic [7:0] prev_code;
    logic       prev_int, prev_con;

    always #2.5 clk = ~clk;   // 200 MHz

    loc_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_win(in_win), .in_smooth(in_smooth), .in_border(in_border),
        .cfg_n8(cfg_n8), .cfg_scale(cfg_scale), .cfg_contrast(cfg_contrast),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
        .out_interior(out_interior), .out_contrast(out_contrast)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: weights per requirement R4/R5, threshold R2/R3, contrast R6.
    function automatic void model(output int code, output int intr, output int con);
        int c, g, ad, thr, rf, nb, w;
        c  = in_win[4*8 +: 8];
        g  = in_smooth;
        ad = (c > g) ? c - g : g - c;
        thr = (cfg_scale * ad) / 16;
        if (thr > 255) thr = 255;
        rf = c - thr;
        code = 0;
        for (int t = 0; t < 9; t++) begin
            if (t == 4) continue;
            nb = in_win[t*8 +: 8];
            if (cfg_n8) w = 1 << ((t < 4) ? t : t - 1);
            else if (t == 1) w = 1;
            else if (t == 3) w = 2;
            else if (t == 5) w = 4;
            else if (t == 7) w = 8;
            else w = 0;
            if (rf >= 0 && nb <= rf) code += w;
        end
        con  = (ad * 256 > cfg_contrast * g) ? 1 : 0;
        intr = 1;
        if (in_border) begin code = 0; intr = 0; con = 0; end
    endfunction

    // Monitor: values are stable at the falling edge for the next rising edge.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (prev_stall) begin
                check(out_valid && out_code == prev_code && out_interior == prev_int &&
                      out_contrast == prev_con, "R9 hold", out_code, prev_code);
            end
            prev_stall = out_valid && !out_ready;
            prev_code  = out_code;
            prev_int   = out_interior;
            prev_con   = out_contrast;
            if (in_valid && in_ready) begin
                int c, i, f;
                model(c, i, f);
                exp_code.push_back(c);
                exp_int.push_back(i);
                exp_con.push_back(f);
                exp_mode.push_back(cfg_n8);
            end
            if (out_valid && out_ready) begin
                if (exp_code.size() == 0) begin
                    check(0, "R9 extra beat", 1, 0);
                end else begin
                    int c, i, f, m;
                    c = exp_code.pop_front();
                    i = exp_int.pop_front();
                    f = exp_con.pop_front();
                    m = exp_mode.pop_front();
                    check(out_code == c, (i == 0) ? "R7 code" : (m ? "R5 code" : "R4 code"),
                          out_code, c);
                    check(out_interior == i, "R7 interior", out_interior, i);
                    check(out_contrast == f, "R6 contrast", out_contrast, f);
                end
            end
        end
    end

    // Consumer ready pattern, changed just after the rising edge.
    always @(posedge clk) begin
        #1;
        out_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    function automatic logic [71:0] win_of(input int c, input int n0, input int n1,
                                           input int n2, input int n3, input int n5,
                                           input int n6, input int n7, input int n8v);
        return {n8v[7:0], n7[7:0], n6[7:0], n5[7:0], c[7:0],
                n3[7:0], n2[7:0], n1[7:0], n0[7:0]};
    endfunction

    // Present one beat and hold it until accepted.
    task automatic send(input logic [71:0] w, input int g, input bit brd, input bit n8,
                        input int sc, input int ct);
        @(posedge clk); #1;
        in_valid = 1; in_win = w; in_smooth = g[7:0]; in_border = brd;
        cfg_n8 = n8; cfg_scale = sc[5:0]; cfg_contrast = ct[7:0];
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && exp_code.size() != 0; k++) @(negedge clk);
        check(exp_code.size() == 0, "R9 drain", exp_code.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check(out_valid == 0, "R10 out_valid", out_valid, 0);
        check(in_ready == 1, "R10 in_ready", in_ready, 1);
        monitor_on = 1;

        // R8: latency of two cycles from an idle pipeline
        @(posedge clk); #1;
        in_valid = 1; in_win = win_of(100, 0,0,0,0,0,0,0,0); in_smooth = 100;
        in_border = 0; cfg_n8 = 0; cfg_scale = 16; cfg_contrast = 0;
        @(negedge clk);
        check(in_ready == 1, "R8 accept", in_ready, 1);
        @(posedge clk); #1 in_valid = 0;
        @(negedge clk);
        check(out_valid == 0, "R8 not early", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1, "R8 at t+2", out_valid, 1);
        drain();

        // R4: flat region gives 15, brighter neighbours give 0
        send(win_of(100, 100,100,100,100,100,100,100,100), 100, 0, 0, 16, 0);
        send(win_of(100, 200,200,200,200,200,200,200,200), 100, 0, 0, 16, 0);
        // R4: only the right neighbour darker -> 4
        send(win_of(100, 150,150,150,150,10,150,150,150), 100, 0, 0, 16, 0);
        // R5: only the left neighbour darker in eight-neighbour mode -> 8
        send(win_of(100, 150,150,150,10,150,150,150,150), 100, 0, 1, 16, 0);
        // R5: diagonals only -> 1+4+32+128
        send(win_of(100, 5,150,5,150,150,5,150,5), 100, 0, 1, 16, 0);
        // R1: ref = 100 - floor(8*8/16) = 96; taps at 96 set, 97 clear
        send(win_of(100, 96,97,96,97,96,97,96,97), 92, 0, 1, 8, 0);
        // R2: thr saturates to 255, ref 0, zero neighbours still count
        send(win_of(255, 0,1,0,1,0,1,0,1), 0, 0, 1, 63, 0);
        // R3: thr 100 above centre 50, nothing counts
        send(win_of(50, 0,0,0,0,0,0,0,0), 0, 0, 1, 32, 0);
        // R6: residual 10 on smooth 100; limit 25 high, 26 low
        send(win_of(110, 0,0,0,0,0,0,0,0), 100, 0, 0, 16, 25);
        send(win_of(110, 0,0,0,0,0,0,0,0), 100, 0, 0, 16, 26);
        // R7: border beat
        send(win_of(200, 0,0,0,0,0,0,0,0), 0, 1, 1, 16, 0);
        drain();

        // R8/R9: random stream, back-to-back, with random stalls
        rand_ready = 1;
        @(posedge clk); #1;
        for (int n = 0; n < 3000; n++) begin
            int c;
            logic [71:0] w;
            c = $urandom_range(0, 255);
            for (int t = 0; t < 9; t++) w[t*8 +: 8] = 8'($urandom_range(0, 255));
            w[4*8 +: 8] = c[7:0];
            in_valid = 1; in_win = w;
            in_smooth = 8'($urandom_range(0, 1) ? c + $urandom_range(0, 40) - 20
                                                 : $urandom_range(0, 255));
            in_border = ($urandom_range(0, 9) == 0);
            cfg_n8 = $urandom_range(0, 1);
            cfg_scale = 6'($urandom_range(0, 63));
            cfg_contrast = 8'($urandom_range(0, 255));
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
            in_valid = 0;
        end
        rand_ready = 0;
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule